// File: doc/BRIEF.md
# Multi-Bank Sigma-Delta Tuning Splitter

This block takes one high-resolution oscillator tuning word and spreads it over three cascaded capacitor banks: coarse, medium and fine. The coarse and medium banks each receive an integer code from a first-order sigma-delta quantizer. The fine bank receives a plain binary word for its DAC. The fine bank gets no further quantization.

The frequency error that each quantizer leaves behind is the first difference of its fractional remainder. That error is multiplied by an adaptive inter-bank gain and added to the input of the next finer bank, so that bank cancels it. The two gains (coarse-to-medium and medium-to-fine) are learned in the background by a sign-data LMS loop. The loop correlates each quantizer's own noise, taken from the previous cycle, with the first difference of the single-bit phase-error signal. A freeze input stops the learning.

The pipeline is three registers deep. Earlier banks are delayed so that all three codes for one input sample leave the block in the same cycle.

Top module: `tuning_splitter`

## Requirements
- R1: After synchronous reset, all three bank codes and all clip flags are zero, and both gains equal GAIN_INIT (4096, which is 16.0 with 8 fraction bits).
- R2: A tuning word whose low 10 bits are zero drives the coarse code to bits [15:10] of the word, the medium code to midscale 32 and the fine code to midscale 128.
- R3: The coarse bank adds the low 10 bits of the word into a 10-bit accumulator every cycle. The coarse code is bits [15:10] plus the accumulator carry. With a half fraction (512) the code alternates between int and int+1, starting with int.
- R4: The medium bank input is 32 + gain_cm/256 × (new − old coarse accumulator)/1024, in medium LSBs. This input is quantized by the medium bank's own first-order sigma-delta, which has 10 fraction bits.
- R5: The codes derived from a word sampled at rising edge n all appear together after edge n+2. Before that, the outputs keep their previous values.
- R6: A coarse code above 63 is clipped to 63, and bit 0 of clip_flags is set in that same output cycle.
- R7: A medium code outside 0..63 is clipped to the nearer limit, and bit 1 of clip_flags is set.
- R8: The fine code is 128 + floor(gain_mf × (new − old medium accumulator) / 2^18), clipped to 0..255, with bit 2 of clip_flags set on a clip.
- R9: When freeze is low, each gain is updated by (s·q) >>> 4 at every edge. Here s = pe_bit − previous pe_bit (+1, 0 or −1), and q is that bank's negated accumulator remainder produced one edge earlier.
- R10: While freeze is high, neither gain changes.
- R11: Each gain saturates at 32767 and −32768 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | 16 | Tuning word: integer coarse part in bits [15:10], fraction in bits [9:0] |
| pe_bit | input | 1 | Single-bit phase-error decision |
| freeze | input | 1 | Holds both gains when high |
| coarse_code | output | 6 | Coarse bank code |
| medium_code | output | 6 | Medium bank code |
| fine_code | output | 8 | Fine DAC word |
| clip_flags | output | 3 | Clip indicators: bit 0 coarse, bit 1 medium, bit 2 fine |
| gain_cm | output | 16 | Coarse-to-medium gain, signed, 8 fraction bits |
| gain_mf | output | 16 | Medium-to-fine gain, signed, 8 fraction bits |

## Verification
The case that matters most is when the learning loop and the range limits act in the same cycles. The phase-error bit is toggled in step with the nonzero coarse residual. This drives the coarse-to-medium gain upward on every other cycle until it meets its positive limit. In those same cycles the gain being clamped is also scaling the forwarded error, and that pushes the medium bank against both of its rails. The run is judged by two checks: the gain must sit exactly at 32767 and stay there, and the medium code must be at 0 or 63 with its clip flag raised.

// File: rtl/tsplit_pkg.sv
package tsplit_pkg;

    localparam int BANK_COARSE = 0;
    localparam int BANK_MEDIUM = 1;
    localparam int BANK_FINE   = 2;
    localparam int NUM_BANKS   = 3;

    // Direction of the phase-error first difference
    typedef enum logic [1:0] {
        PSTEP_HOLD = 2'd0,
        PSTEP_RISE = 2'd1,
        PSTEP_FALL = 2'd2
    } pstep_e;

    function automatic pstep_e phase_step(input logic now_bit, input logic prev_bit);
        if (now_bit && !prev_bit) return PSTEP_RISE;
        if (!now_bit && prev_bit) return PSTEP_FALL;
        return PSTEP_HOLD;
    endfunction

endpackage

// File: rtl/sd_bank_stage.sv
module sd_bank_stage #(
    parameter int XW     = 24,
    parameter int FRAC   = 10,
    parameter int CODE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [XW-1:0]     x_in,
    output logic [CODE_W-1:0]        code,
    output logic                     clip,
    output logic signed [FRAC+1:0]   fwd,
    output logic signed [FRAC:0]     qerr
);
    localparam int IW = XW - FRAC;
    localparam int RW = IW + 1;
    localparam logic signed [RW-1:0] MAXV = RW'((1 << CODE_W) - 1);

    logic [FRAC-1:0]        acc_q;
    logic [FRAC-1:0]        frac_w;
    logic [FRAC-1:0]        acc_next;
    logic [FRAC:0]          sum_w;
    logic                   carry;
    logic signed [IW-1:0]   int_w;
    logic signed [RW-1:0]   raw;
    logic [CODE_W-1:0]      code_n;
    logic                   clip_n;
    logic signed [FRAC+1:0] fwd_n;
    logic signed [FRAC:0]   qerr_n;

    always_comb begin
        frac_w   = x_in[FRAC-1:0];
        int_w    = x_in[XW-1:FRAC];
        sum_w    = {1'b0, acc_q} + {1'b0, frac_w};
        carry    = sum_w[FRAC];
        acc_next = sum_w[FRAC-1:0];
        raw      = {int_w[IW-1], int_w} + {{(RW-1){1'b0}}, carry};
        if (raw[RW-1]) begin
            code_n = '0;
            clip_n = 1'b1;
        end else if (raw > MAXV) begin
            code_n = {CODE_W{1'b1}};
            clip_n = 1'b1;
        end else begin
            code_n = raw[CODE_W-1:0];
            clip_n = 1'b0;
        end
        fwd_n  = $signed({2'b00, acc_next}) - $signed({2'b00, acc_q});
        qerr_n = -$signed({1'b0, acc_next});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            code  <= '0;
            clip  <= 1'b0;
            fwd   <= '0;
            qerr  <= '0;
        end else begin
            acc_q <= acc_next;
            code  <= code_n;
            clip  <= clip_n;
            fwd   <= fwd_n;
            qerr  <= qerr_n;
        end
    end

endmodule

// File: rtl/gain_mult.sv
module gain_mult #(
    parameter int GW = 16,
    parameter int DW = 12,
    parameter int SH = 8,
    parameter int OW = 24
) (
    input  logic signed [GW-1:0] gain,
    input  logic signed [DW-1:0] dat,
    output logic signed [OW-1:0] result
);
    localparam int PW = GW + DW;

    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] d_ext;
    logic signed [PW-1:0] prod;

    always_comb begin
        g_ext  = {{DW{gain[GW-1]}}, gain};
        d_ext  = {{GW{dat[DW-1]}}, dat};
        prod   = g_ext * d_ext;
        result = OW'(prod >>> SH);
    end

endmodule

// File: rtl/inter_bank_lms.sv
module inter_bank_lms
    import tsplit_pkg::*;
#(
    parameter int GW        = 16,
    parameter int FRAC      = 10,
    parameter int MU_SH     = 4,
    parameter int GAIN_INIT = 4096
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  freeze,
    input  pstep_e                step,
    input  logic signed [FRAC:0]  qerr,
    output logic signed [GW-1:0]  gain
);
    localparam int AW = GW + 2;
    localparam logic signed [AW-1:0] GMAX = AW'((1 << (GW-1)) - 1);
    localparam logic signed [AW-1:0] GMIN = -AW'(1 << (GW-1));

    logic signed [AW-1:0] q_ext;
    logic signed [AW-1:0] delta;
    logic signed [AW-1:0] stepped;
    logic signed [AW-1:0] g_ext;
    logic signed [AW-1:0] total;
    logic signed [GW-1:0] gain_n;

    always_comb begin
        q_ext = {{(AW-FRAC-1){qerr[FRAC]}}, qerr};
        unique case (step)
            PSTEP_RISE: delta = q_ext;
            PSTEP_FALL: delta = -q_ext;
            default:    delta = '0;
        endcase
        stepped = delta >>> MU_SH;
        g_ext   = {{2{gain[GW-1]}}, gain};
        total   = g_ext + stepped;
        if (total > GMAX)      gain_n = GMAX[GW-1:0];
        else if (total < GMIN) gain_n = GMIN[GW-1:0];
        else                   gain_n = total[GW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)          gain <= GW'(GAIN_INIT);
        else if (!freeze) gain <= gain_n;
    end

endmodule

// File: rtl/align_delay.sv
module align_delay #(
    parameter int W     = 7,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] taps [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tap
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) taps[0] <= '0;
                    else     taps[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) taps[i] <= '0;
                    else     taps[i] <= taps[i-1];
                end
            end
        end
    endgenerate

    assign dout = taps[DEPTH-1];

endmodule

// File: rtl/tuning_splitter.sv
module tuning_splitter
    import tsplit_pkg::*;
#(
    parameter int CW        = 6,
    parameter int MW        = 6,
    parameter int FW        = 8,
    parameter int FRAC      = 10,
    parameter int GW        = 16,
    parameter int GF        = 8,
    parameter int MU_SH     = 4,
    parameter int GAIN_INIT = 4096
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CW+FRAC-1:0]   tune_word,
    input  logic                 pe_bit,
    input  logic                 freeze,
    output logic [CW-1:0]        coarse_code,
    output logic [MW-1:0]        medium_code,
    output logic [FW-1:0]        fine_code,
    output logic [2:0]           clip_flags,
    output logic signed [GW-1:0] gain_cm,
    output logic signed [GW-1:0] gain_mf
);
    localparam int TW  = CW + FRAC;
    localparam int XW  = TW + 8;
    localparam int DW  = FRAC + 2;
    localparam int NG  = NUM_BANKS - 1;
    localparam logic signed [XW-1:0] MED_BASE  = XW'((1 << (MW-1)) * (1 << FRAC));
    localparam logic signed [XW-1:0] FINE_BASE = XW'(1 << (FW-1));
    localparam logic signed [XW-1:0] FINE_MAX  = XW'((1 << FW) - 1);

    // stage outputs
    logic [CW-1:0]          c_code;
    logic                   c_clip;
    logic [MW-1:0]          m_code;
    logic                   m_clip;
    logic signed [DW-1:0]   fwd_arr  [NG];
    logic signed [FRAC:0]   qerr_arr [NG];
    logic signed [GW-1:0]   gain_arr [NG];

    logic signed [XW-1:0]   x_coarse;
    logic signed [XW-1:0]   scaled_m;
    logic signed [XW-1:0]   x_medium;
    logic signed [XW-1:0]   scaled_f;
    logic signed [XW-1:0]   x_fine;

    logic                   pe_q;
    pstep_e                 pstep;

    logic [CW:0]            coarse_al;
    logic [MW:0]            medium_al;
    logic [FW-1:0]          fine_q;
    logic                   fine_clip_q;

    assign x_coarse = {{(XW-TW){1'b0}}, tune_word};

    sd_bank_stage #(.XW(XW), .FRAC(FRAC), .CODE_W(CW)) u_coarse (
        .clk  (clk),
        .rst  (rst),
        .x_in (x_coarse),
        .code (c_code),
        .clip (c_clip),
        .fwd  (fwd_arr[BANK_COARSE]),
        .qerr (qerr_arr[BANK_COARSE])
    );

    gain_mult #(.GW(GW), .DW(DW), .SH(GF), .OW(XW)) u_mult_cm (
        .gain   (gain_arr[BANK_COARSE]),
        .dat    (fwd_arr[BANK_COARSE]),
        .result (scaled_m)
    );

    assign x_medium = MED_BASE + scaled_m;

    sd_bank_stage #(.XW(XW), .FRAC(FRAC), .CODE_W(MW)) u_medium (
        .clk  (clk),
        .rst  (rst),
        .x_in (x_medium),
        .code (m_code),
        .clip (m_clip),
        .fwd  (fwd_arr[BANK_MEDIUM]),
        .qerr (qerr_arr[BANK_MEDIUM])
    );

    gain_mult #(.GW(GW), .DW(DW), .SH(GF + FRAC), .OW(XW)) u_mult_mf (
        .gain   (gain_arr[BANK_MEDIUM]),
        .dat    (fwd_arr[BANK_MEDIUM]),
        .result (scaled_f)
    );

    assign x_fine = FINE_BASE + scaled_f;

    // fine bank: plain binary word, clipped
    always_ff @(posedge clk) begin
        if (rst) begin
            fine_q      <= '0;
            fine_clip_q <= 1'b0;
        end else if (x_fine < 0) begin
            fine_q      <= '0;
            fine_clip_q <= 1'b1;
        end else if (x_fine > FINE_MAX) begin
            fine_q      <= {FW{1'b1}};
            fine_clip_q <= 1'b1;
        end else begin
            fine_q      <= x_fine[FW-1:0];
            fine_clip_q <= 1'b0;
        end
    end

    // phase-error first difference
    always_ff @(posedge clk) begin
        if (rst) pe_q <= 1'b0;
        else     pe_q <= pe_bit;
    end

    assign pstep = phase_step(pe_bit, pe_q);

    generate
        for (genvar b = 0; b < NG; b++) begin : g_lms
            inter_bank_lms #(
                .GW(GW), .FRAC(FRAC), .MU_SH(MU_SH), .GAIN_INIT(GAIN_INIT)
            ) u_lms (
                .clk    (clk),
                .rst    (rst),
                .freeze (freeze),
                .step   (pstep),
                .qerr   (qerr_arr[b]),
                .gain   (gain_arr[b])
            );
        end
    endgenerate

    // align coarse and medium codes with the fine word
    align_delay #(.W(CW + 1), .DEPTH(2)) u_align_c (
        .clk  (clk),
        .rst  (rst),
        .din  ({c_clip, c_code}),
        .dout (coarse_al)
    );

    align_delay #(.W(MW + 1), .DEPTH(1)) u_align_m (
        .clk  (clk),
        .rst  (rst),
        .din  ({m_clip, m_code}),
        .dout (medium_al)
    );

    assign coarse_code = coarse_al[CW-1:0];
    assign medium_code = medium_al[MW-1:0];
    assign fine_code   = fine_q;
    assign clip_flags  = {fine_clip_q, medium_al[MW], coarse_al[CW]};
    assign gain_cm     = gain_arr[BANK_COARSE];
    assign gain_mf     = gain_arr[BANK_MEDIUM];

endmodule

// File: rtl/tuning_splitter_chk.sv
module tuning_splitter_chk #(
    parameter int CW = 6,
    parameter int MW = 6,
    parameter int GW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 freeze,
    input logic [CW-1:0]        coarse_code,
    input logic [MW-1:0]        medium_code,
    input logic [2:0]           clip_flags,
    input logic signed [GW-1:0] gain_cm,
    input logic signed [GW-1:0] gain_mf
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam logic [MW-1:0] MMAX = {MW{1'b1}};
    localparam logic signed [GW-1:0] GHALF = GW'(1 << (GW-2));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (clip_flags == 3'b000 && coarse_code == '0 && medium_code == '0));

    // R6
    coarse_clip_chk: assert property (@(posedge clk) disable iff (rst)
        clip_flags[0] |-> (coarse_code == CMAX));

    // R7
    medium_clip_chk: assert property (@(posedge clk) disable iff (rst)
        clip_flags[1] |-> (medium_code == '0 || medium_code == MMAX));

    // R10
    freeze_cm_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(freeze)) |-> $stable(gain_cm));

    // R10
    freeze_mf_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(freeze)) |-> $stable(gain_mf));

    // R11
    gain_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !(($past(gain_cm) > GHALF) && (gain_cm < 0)));

endmodule

bind tuning_splitter tuning_splitter_chk #(.CW(CW), .MW(MW), .GW(GW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .freeze      (freeze),
    .coarse_code (coarse_code),
    .medium_code (medium_code),
    .clip_flags  (clip_flags),
    .gain_cm     (gain_cm),
    .gain_mf     (gain_mf)
);

// File: tb/tuning_splitter_bench.sv
`timescale 1ns/1ps
module tuning_splitter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tune_word = '0;
    logic        pe_bit = 1'b0;
    logic        freeze = 1'b1;
    logic [5:0]  coarse_code;
    logic [5:0]  medium_code;
    logic [7:0]  fine_code;
    logic [2:0]  clip_flags;
    logic signed [15:0] gain_cm;
    logic signed [15:0] gain_mf;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tuning_splitter u_tuning_splitter (
        .clk         (clk),
        .rst         (rst),
        .tune_word   (tune_word),
        .pe_bit      (pe_bit),
        .freeze      (freeze),
        .coarse_code (coarse_code),
        .medium_code (medium_code),
        .fine_code   (fine_code),
        .clip_flags  (clip_flags),
        .gain_cm     (gain_cm),
        .gain_mf     (gain_mf)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // packs coarse, medium, fine, flags as decimal c*1e6 + m*1e4 + f*10 + flags
    function automatic int pack(input int c, input int m, input int f, input int fl);
        return c * 1000000 + m * 10000 + f * 10 + fl;
    endfunction

    task automatic check_codes(input string tag, input int c, input int m, input int f, input int fl);
        check(tag, pack(int'(coarse_code), int'(medium_code), int'(fine_code), int'(clip_flags)),
              pack(c, m, f, fl));
    endtask

    task automatic apply_reset(input logic [15:0] tw, input logic pe, input logic frz);
        @(negedge clk);
        rst = 1'b1;
        tune_word = tw;
        pe_bit = pe;
        freeze = frz;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        apply_reset(16'd0, 1'b0, 1'b1);
        check_codes("R1 codes and flags after reset", 0, 0, 0, 0);
        check("R1 gain_cm init", int'(gain_cm), 4096);
        check("R1 gain_mf init", int'(gain_mf), 4096);
    endtask

    task automatic t_integer();
        apply_reset(16'(20 << 10), 1'b0, 1'b1);
        step(); step();
        check("R5 coarse not yet out after edge 2", int'(coarse_code), 0);
        step();
        check_codes("R2 R5 integer word edge 3", 20, 32, 128, 0);
        step();
        check_codes("R2 integer word steady", 20, 32, 128, 0);
    endtask

    task automatic t_half();
        apply_reset(16'((20 << 10) | 512), 1'b0, 1'b1);
        step(); step(); step();
        check_codes("R3 R4 half fraction first", 20, 40, 128, 0);
        step();
        check_codes("R3 R4 half fraction carry", 21, 24, 128, 0);
        step();
        check_codes("R3 half fraction repeats", 20, 40, 128, 0);
    endtask

    task automatic t_fine();
        apply_reset(16'((20 << 10) | 31), 1'b0, 1'b1);
        step(); step(); step();
        check_codes("R8 fine positive residual", 20, 32, 135, 0);
        step(); step();
        check_codes("R8 R4 fine after medium carry", 20, 33, 119, 0);
    endtask

    task automatic t_coarse_clip();
        apply_reset(16'((63 << 10) | 512), 1'b0, 1'b1);
        step(); step(); step();
        check_codes("R6 coarse at top no clip", 63, 40, 128, 0);
        step();
        check_codes("R6 coarse clipped", 63, 24, 128, 1);
    endtask

    task automatic t_lms();
        apply_reset(16'((20 << 10) | 512), 1'b0, 1'b0);
        step();
        pe_bit = 1'b1; step();
        check("R9 gain_cm after rise with q=-512", int'(gain_cm), 4064);
        pe_bit = 1'b0; step();
        pe_bit = 1'b1; step();
        check("R9 gain_cm after second update", int'(gain_cm), 4032);
    endtask

    task automatic t_freeze();
        apply_reset(16'((20 << 10) | 512), 1'b0, 1'b1);
        step();
        pe_bit = 1'b1; step();
        pe_bit = 1'b0; step();
        pe_bit = 1'b1; step();
        check("R10 gain_cm held", int'(gain_cm), 4096);
        check("R10 gain_mf held", int'(gain_mf), 4096);
    endtask

    task automatic t_gain_sat();
        apply_reset(16'((20 << 10) | 512), 1'b1, 1'b0);
        for (int i = 0; i < 2400; i++) begin
            pe_bit = (i % 2 == 0);
            step();
        end
        check("R11 gain_cm at positive limit", int'(gain_cm), 32767);
        check("R7 medium at rail with flag",
              int'(clip_flags[1] && (medium_code == 6'd0 || medium_code == 6'd63)), 1);
        for (int i = 0; i < 6; i++) begin
            pe_bit = (i % 2 == 0);
            step();
        end
        check("R11 gain_cm stays at limit", int'(gain_cm), 32767);
    endtask

    initial begin
        t_reset();
        t_integer();
        t_half();
        t_fine();
        t_coarse_clip();
        t_lms();
        t_freeze();
        t_gain_sat();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule